// File: doc/BRIEF.md
# System Control Port A Register

This block is the one-byte system control register that a PC-compatible chipset places at I/O address 0x92. Software uses it to open or close the A20 address gate, to request a fast CPU reset without going through the keyboard controller, to lock a protected area of battery-backed configuration memory, to see whether a watchdog timeout has happened, and to switch a front-panel activity light.

The bits do not share a lifetime. The fast-reset flag and the lock bit survive a CPU reset and clear only on power-on reset, so boot code can find out how it was restarted. The watchdog flag also survives a CPU reset; software clears it by writing 1 to it. A20 and the activity bits return to zero on either reset. Writing 1 to bit 0 starts a CPU-reset pulse of fixed length, and the rest of that write is discarded.

The pulse is produced by a small state machine with two states. PS_IDLE is the rest state. It moves to PS_DRIVE on an accepted write that has bit 0 set. PS_DRIVE holds the reset output high while it counts cycles. It returns to PS_IDLE when its count reaches the pulse length. A write that has bit 0 set and arrives in PS_DRIVE does not change the state or the count.

Top module: `sysctl_porta`

## Requirements
- R1: An access at address 0x92 with `io_byte` low raises `size_err` for exactly the one cycle after the access. A write of this kind changes no register bit, and a read of this kind returns 0.
- R2: A byte write to 0x92 with bit 0 clear sets `a20_en` to data bit 1 from the next cycle on. A byte read returns the current A20 state in bit 1.
- R3: A byte write to 0x92 with bit 0 set, issued while the pulse machine is in PS_IDLE, drives `cpu_rst_pulse` high for exactly 4 cycles, starting in the cycle after the write.
- R4: A byte write with bit 0 set applies none of its other bits. A20, lock, watchdog flag and activity bits all keep their values.
- R5: A write with bit 0 set that arrives while the pulse is high neither lengthens nor restarts the pulse.
- R6: Register bit 0 reads 1 after a fast-reset write. It stays 1 through CPU reset, and only power-on reset clears it.
- R7: Writing 1 to bit 3 sets the lock, which reads back in bit 3 and drives `sec_lock`. Writing 0 to bit 3 has no effect, and CPU reset does not clear the lock.
- R8: `wdog_to` sets register bit 4. A byte write with bit 0 clear and bit 4 set clears bit 4, unless `wdog_to` is high in the same cycle. CPU reset keeps bit 4.
- R9: Bits 7 and 6 store the written value. `act_led` is high when either bit is 1.
- R10: Bits 5 and 2 always read 0.
- R11: Power-on reset (`por_n` low) clears every bit, so A20 is disabled. CPU reset (`cpu_rst` high) clears A20 and bits 7:6, keeps bits 0, 3 and 4, and causes bus writes in that cycle to be ignored.
- R12: Accesses to any other address change nothing and read back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cpu_rst | input | 1 | Synchronous CPU reset, active high |
| io_addr | input | 16 | I/O address |
| io_byte | input | 1 | High when the access is one byte wide |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of `io_rd` |
| size_err | output | 1 | Pulses for one cycle after an access to 0x92 that is not byte-wide |
| wdog_to | input | 1 | Watchdog timeout indication |
| a20_en | output | 1 | A20 gate enable |
| cpu_rst_pulse | output | 1 | Fast CPU reset request |
| sec_lock | output | 1 | Security lock state |
| act_led | output | 1 | Activity light |

## Verification
The bench issues a fast-reset write with bit 1 and bits 7:6 clear. A design that applied the rest of the write would drop A20 and turn off the light, and a design that restarted the pulse on a second trigger would hold `cpu_rst_pulse` high for longer than 4 cycles. The bench asserts CPU reset with the fast-reset flag, the lock and the watchdog flag all set, and expects those three bits to remain while A20 and the light go off. A design that used one reset for every bit fails this check. The bench also tests a write of 0 to a set lock bit, a watchdog flag clear that races a new timeout, and non-byte accesses, which must raise the error flag without touching A20.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    // Bit positions inside the control byte (software visible layout)
    localparam int BIT_FRST  = 0;
    localparam int BIT_A20   = 1;
    localparam int BIT_LOCK  = 3;
    localparam int BIT_WDOG  = 4;
    localparam int BIT_ACT_L = 6;
    localparam int BIT_ACT_H = 7;

    typedef enum logic [0:0] {
        PS_IDLE  = 1'b0,
        PS_DRIVE = 1'b1
    } pulse_state_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h92
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_byte,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              size_err
);
    logic hit;
    logic bad_size;

    assign hit      = (io_addr == BASE_ADDR);
    assign rd_ok    = hit && io_byte && io_rd;
    assign wr_ok    = hit && io_byte && io_wr;
    assign bad_size = hit && !io_byte && (io_rd || io_wr);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) size_err <= 1'b0;
        else        size_err <= bad_size;
    end

    // R1: the error flag only follows a mis-sized access one cycle earlier
    assert_size_err_cause_R1: assert property (@(posedge clk) disable iff (!por_n)
        size_err |-> $past(hit && !io_byte && (io_rd || io_wr)));
endmodule

// File: rtl/sysctl_rstpulse.sv
module sysctl_rstpulse
    import sysctl_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic trig,
    output logic pulse
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    pulse_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_IDLE: begin
                if (trig) begin
                    state_d = PS_DRIVE;
                    cnt_d   = '0;
                end
            end
            PS_DRIVE: begin
                if (cnt_q == LAST) begin
                    state_d = PS_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = PS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PS_DRIVE: pulse = 1'b1;
            default:  pulse = 1'b0;
        endcase
    end

    // run-length monitor for the pulse width
    logic [CNT_W:0] hi_run;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     hi_run <= '0;
        else if (pulse) hi_run <= hi_run + 1'b1;
        else            hi_run <= '0;
    end

    // R3/R5: the pulse never runs longer than the configured width
    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!por_n)
        hi_run <= (CNT_W+1)'(PULSE_CYCLES));
    // R3: a pulse that has started keeps going until its width is reached
    assert_pulse_min_R3: assert property (@(posedge clk) disable iff (!por_n)
        (pulse && hi_run < (CNT_W+1)'(PULSE_CYCLES - 1)) |=> pulse);
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       cpu_rst,
    input  logic       wr_ok,
    input  logic [7:0] wdata,
    input  logic       wdog_to,
    output logic [7:0] value,
    output logic       a20_en,
    output logic       sec_lock,
    output logic       act_led
);
    logic       frst_q;
    logic       a20_q;
    logic       lock_q;
    logic       wdog_q;
    logic [1:0] act_q;
    logic       normal_wr;
    logic       fire_wr;

    assign fire_wr   = wr_ok && !cpu_rst && wdata[BIT_FRST];
    assign normal_wr = wr_ok && !cpu_rst && !wdata[BIT_FRST];

    // bits cleared by either reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            a20_q <= 1'b0;
            act_q <= 2'b00;
        end else if (cpu_rst) begin
            a20_q <= 1'b0;
            act_q <= 2'b00;
        end else if (normal_wr) begin
            a20_q <= wdata[BIT_A20];
            act_q <= wdata[BIT_ACT_H:BIT_ACT_L];
        end
    end

    // bits cleared only by power-on reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            frst_q <= 1'b0;
            lock_q <= 1'b0;
            wdog_q <= 1'b0;
        end else begin
            if (fire_wr) frst_q <= 1'b1;
            if (normal_wr && wdata[BIT_LOCK]) lock_q <= 1'b1;
            if (wdog_to)
                wdog_q <= 1'b1;
            else if (normal_wr && wdata[BIT_WDOG])
                wdog_q <= 1'b0;
        end
    end

    always_comb begin
        value            = '0;
        value[BIT_FRST]  = frst_q;
        value[BIT_A20]   = a20_q;
        value[BIT_LOCK]  = lock_q;
        value[BIT_WDOG]  = wdog_q;
        value[BIT_ACT_H:BIT_ACT_L] = act_q;
    end

    assign a20_en   = a20_q;
    assign sec_lock = lock_q;
    assign act_led  = |act_q;

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        sec_lock |=> sec_lock);
    assert_frst_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
        value[BIT_FRST] |=> value[BIT_FRST]);
    assert_wdog_sets_R8: assert property (@(posedge clk) disable iff (!por_n)
        wdog_to |=> value[BIT_WDOG]);
    assert_cpu_rst_clears_R11: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst |=> (!a20_en && !act_led));
    assert_fire_keeps_a20_R4: assert property (@(posedge clk) disable iff (!por_n)
        (wr_ok && wdata[BIT_FRST]) |=> $stable(a20_en));
endmodule

// File: rtl/sysctl_porta.sv
module sysctl_porta
    import sysctl_pkg::*;
#(
    parameter int              ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h92,
    parameter int              PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              cpu_rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_byte,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              size_err,
    input  logic              wdog_to,
    output logic              a20_en,
    output logic              cpu_rst_pulse,
    output logic              sec_lock,
    output logic              act_led
);
    logic       rd_ok;
    logic       wr_ok;
    logic       trig;
    logic [7:0] reg_value;

    sysctl_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .clk      (clk),
        .por_n    (por_n),
        .io_addr  (io_addr),
        .io_byte  (io_byte),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .size_err (size_err)
    );

    sysctl_regs u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .cpu_rst  (cpu_rst),
        .wr_ok    (wr_ok),
        .wdata    (io_wdata),
        .wdog_to  (wdog_to),
        .value    (reg_value),
        .a20_en   (a20_en),
        .sec_lock (sec_lock),
        .act_led  (act_led)
    );

    assign trig = wr_ok && !cpu_rst && io_wdata[BIT_FRST];

    sysctl_rstpulse #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_pulse (
        .clk   (clk),
        .por_n (por_n),
        .trig  (trig),
        .pulse (cpu_rst_pulse)
    );

    assign io_rdata = rd_ok ? reg_value : 8'h00;

    // R3: an accepted trigger while idle starts the pulse in the next cycle
    assert_trig_starts_R3: assert property (@(posedge clk) disable iff (!por_n)
        (trig && !cpu_rst_pulse) |=> cpu_rst_pulse);
    // R10: unused bits never read as 1
    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!por_n)
        (io_rdata[5] == 1'b0) && (io_rdata[2] == 1'b0));
endmodule

// File: tb/tb_sysctl_porta.sv
module tb_sysctl_porta;
    localparam int S_RDATA = 0;
    localparam int S_A20   = 1;
    localparam int S_PULSE = 2;
    localparam int S_LOCK  = 3;
    localparam int S_LED   = 4;
    localparam int S_ERR   = 5;

    typedef struct {
        int         due;
        int         sig;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        cpu_rst = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_byte = 1'b1;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        wdog_to = 1'b0;
    logic [7:0]  io_rdata;
    logic        size_err, a20_en, cpu_rst_pulse, sec_lock, act_led;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sysctl_porta dut (
        .clk(clk), .por_n(por_n), .cpu_rst(cpu_rst), .io_addr(io_addr),
        .io_byte(io_byte), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .size_err(size_err), .wdog_to(wdog_to),
        .a20_en(a20_en), .cpu_rst_pulse(cpu_rst_pulse), .sec_lock(sec_lock),
        .act_led(act_led)
    );

    function automatic logic [7:0] sample(int sig);
        case (sig)
            S_RDATA: return io_rdata;
            S_A20:   return {7'b0, a20_en};
            S_PULSE: return {7'b0, cpu_rst_pulse};
            S_LOCK:  return {7'b0, sec_lock};
            S_LED:   return {7'b0, act_led};
            default: return {7'b0, size_err};
        endcase
    endfunction

    task automatic expect_at(int sig, logic [7:0] exp, int delay, string req);
        item_t it;
        it.due = cyc + delay;
        it.sig = sig;
        it.exp = exp;
        it.req = req;
        sb.push_back(it);
    endtask

    // monitor: pops due items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = 0; i < sb.size(); ) begin
                if (sb[i].due <= cyc) begin
                    logic [7:0] act;
                    act = sample(sb[i].sig);
                    checks++;
                    if (sb[i].due < cyc || act !== sb[i].exp) begin
                        errors++;
                        $display("FAIL %s sig%0d cycle %0d: actual %02h expected %02h",
                                 sb[i].req, sb[i].sig, sb[i].due, act, sb[i].exp);
                    end
                    sb.delete(i);
                end else begin
                    i++;
                end
            end
        end
    end

    task automatic wr(logic [15:0] a, logic [7:0] d, logic byte_ok = 1'b1);
        io_addr = a; io_wdata = d; io_byte = byte_ok; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_byte = 1'b1;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] exp, string req, logic byte_ok = 1'b1);
        io_addr = a; io_byte = byte_ok; io_rd = 1'b1;
        expect_at(S_RDATA, exp, 0, req);
        @(negedge clk);
        io_rd = 1'b0; io_byte = 1'b1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                    $display("CHECKS %0d ERRORS %0d", checks, errors);
                    $finish;
                end
            end
        join_none

        idle(2);
        por_n = 1'b1;
        idle(1);
        // R11: power-on state
        rd(16'h0092, 8'h00, "R11 por readback");
        expect_at(S_A20, 0, 0, "R11 a20 off");
        expect_at(S_PULSE, 0, 0, "R11 pulse low");
        expect_at(S_LOCK, 0, 0, "R11 lock clear");
        idle(1);

        // R2: A20 control
        wr(16'h0092, 8'h02);
        expect_at(S_A20, 1, 0, "R2 a20 on");
        rd(16'h0092, 8'h02, "R2 readback");

        // R9: activity bits
        wr(16'h0092, 8'hC2);
        expect_at(S_LED, 1, 0, "R9 led both");
        rd(16'h0092, 8'hC2, "R9 readback");
        wr(16'h0092, 8'h42);
        expect_at(S_LED, 1, 0, "R9 led bit6");
        wr(16'h0092, 8'h82);
        expect_at(S_LED, 1, 0, "R9 led bit7");
        wr(16'h0092, 8'h02);
        expect_at(S_LED, 0, 0, "R9 led off");

        // R10: unused bits
        wr(16'h0092, 8'h26);
        rd(16'h0092, 8'h02, "R10 unused bits zero");

        // R12: other addresses
        wr(16'h0093, 8'h00);
        wr(16'h0192, 8'hC8);
        expect_at(S_A20, 1, 0, "R12 a20 untouched");
        expect_at(S_LOCK, 0, 0, "R12 lock untouched");
        rd(16'h0093, 8'h00, "R12 other addr read");
        rd(16'h0092, 8'h02, "R12 reg unchanged");

        // R1: non-byte accesses
        io_addr = 16'h0092; io_wdata = 8'h00; io_byte = 1'b0; io_wr = 1'b1;
        expect_at(S_ERR, 1, 1, "R1 err after write");
        expect_at(S_ERR, 0, 2, "R1 err one cycle");
        @(negedge clk);
        io_wr = 1'b0; io_byte = 1'b1;
        expect_at(S_A20, 1, 0, "R1 a20 kept");
        idle(1);
        rd(16'h0092, 8'h00, "R1 bad read zero", 1'b0);
        expect_at(S_ERR, 1, 0, "R1 err after read");
        idle(1);

        // R7: lock
        wr(16'h0092, 8'h0A);
        expect_at(S_LOCK, 1, 0, "R7 lock set");
        wr(16'h0092, 8'h02);
        expect_at(S_LOCK, 1, 0, "R7 write zero ignored");
        rd(16'h0092, 8'h0A, "R7 readback");

        // R8: watchdog flag
        wdog_to = 1'b1; idle(1); wdog_to = 1'b0;
        rd(16'h0092, 8'h1A, "R8 wdog set");
        wr(16'h0092, 8'h12);
        rd(16'h0092, 8'h0A, "R8 wdog cleared");
        wdog_to = 1'b1;
        wr(16'h0092, 8'h12);
        wdog_to = 1'b0;
        rd(16'h0092, 8'h1A, "R8 set beats clear");

        // prepare: activity on, keep wdog, lock, a20
        wr(16'h0092, 8'hCA);
        wdog_to = 1'b1; idle(1); wdog_to = 1'b0;
        rd(16'h0092, 8'hDA, "R9 state before fire");

        // R3/R4/R5: fast reset
        io_addr = 16'h0092; io_wdata = 8'h01; io_wr = 1'b1;
        expect_at(S_PULSE, 0, 0, "R3 pulse not before");
        for (int d = 1; d <= 4; d++) expect_at(S_PULSE, 1, d, "R3 pulse high");
        expect_at(S_PULSE, 0, 5, "R5 pulse not extended");
        @(negedge clk);
        io_wr = 1'b0;
        expect_at(S_A20, 1, 0, "R4 a20 kept");
        expect_at(S_LED, 1, 0, "R4 led kept");
        wr(16'h0092, 8'h01);   // retrigger during pulse
        idle(5);
        expect_at(S_PULSE, 0, 0, "R5 no restart");
        rd(16'h0092, 8'hDB, "R4 R6 readback after fire");

        // R11/R6: CPU reset
        cpu_rst = 1'b1;
        io_addr = 16'h0092; io_wdata = 8'h02; io_wr = 1'b1;
        @(negedge clk);
        cpu_rst = 1'b0; io_wr = 1'b0;
        expect_at(S_A20, 0, 0, "R11 cpu rst a20");
        expect_at(S_LED, 0, 0, "R11 cpu rst led");
        expect_at(S_LOCK, 1, 0, "R7 lock survives");
        rd(16'h0092, 8'h19, "R6 R8 bits kept");

        // R11/R6: power-on reset
        por_n = 1'b0; idle(1); por_n = 1'b1;
        rd(16'h0092, 8'h00, "R6 por clears");
        expect_at(S_LOCK, 0, 0, "R11 por lock");
        idle(3);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule